// File: doc/BRIEF.md
# Serial Divide-Ratio Loader

This block takes divide-ratio words from a host over a three-wire serial link: a data line, a bit clock and a load strobe. It turns them into the values that drive a frequency synthesizer's divider chain: the reference divider value, the prescaler modulus-select bit, the main (programmable) divider value and the swallow divider value. The host shifts in one word, most significant bit first, and then pulses the strobe. The last bit shifted, which is the word's least significant bit, says which register bank the strobe updates.

All three link lines are asynchronous to the system clock. Each passes through a synchronizer, and edge detection works on the synchronized levels. The block counts the bits shifted since the previous strobe. A strobe whose count does not match the length that the control bit calls for is refused. The divider outputs then keep their values and an error flag rises. A one-cycle done pulse marks every accepted transfer.

Top module: `ser_divratio_load`

## Requirements
- R1: After reset, all divider outputs, the modulus-select bit, the done pulse and the error flag are 0.
- R2: A word of 2+R_W bits (16 by default) whose bit 0 is 1 is a reference word. On the strobe, bits R_W..1 go to the reference divider output and bit R_W+1 goes to the modulus-select output. The main and swallow outputs keep their values.
- R3: A word of 1+A_W+N_W bits (19 by default) whose bit 0 is 0 is a counter word. On the strobe, bits A_W..1 go to the swallow output and bits A_W+N_W..A_W+1 go to the main output. The reference and modulus-select outputs keep their values.
- R4: Bits arrive most significant first, one per rising edge of the serial clock, so bit 0 (the control bit) is the last bit shifted before the strobe.
- R5: A strobe whose received bit count differs from the length that its control bit selects changes no divider output, gives no done pulse, and sets the error flag.
- R6: The error flag stays set until the next accepted transfer, which clears it.
- R7: Each accepted transfer gives exactly one done pulse, one system clock long, in the same cycle that the outputs take their new values.
- R8: Each strobe restarts the bit count, so a strobe that has no bits since the previous strobe is refused.
- R9: A word with more bits than its selected length is refused, including bit counts beyond the longest format.
- R10: Changes on the data line that have no rising serial clock edge shift nothing and do not add to the bit count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk_i | input | 1 | Serial bit clock, asynchronous |
| ser_dat_i | input | 1 | Serial data, asynchronous |
| ser_ld_i | input | 1 | Load strobe, asynchronous |
| ref_div_o | output | R_W | Reference divider value |
| mod_sel_o | output | 1 | Prescaler modulus select |
| main_div_o | output | N_W | Main (programmable) divider value |
| swal_div_o | output | A_W | Swallow divider value |
| load_done_o | output | 1 | One-cycle pulse on an accepted transfer |
| len_err_o | output | 1 | Set by a refused strobe, cleared by an accepted one |

## Verification
The bench keeps the default field widths of 14, 7 and 11 bits, so both word formats have their standard lengths of 16 and 19 bits. The longer format then sets the shift register width and the bit counter saturates just above it. It raises the synchronizer depth to three stages. This makes the delay from a link edge to an output change longer than the default, and the reference model has to allow for that settling window. With these values the bench can send words one bit short, one bit long and far beyond the longest format. It can also send a control bit that does not match the word length, and it sends back-to-back strobes.

// File: rtl/slink_pkg.sv
package slink_pkg;

    // Default field widths of the two word formats.
    parameter int unsigned DEF_R_W   = 14;
    parameter int unsigned DEF_A_W   = 7;
    parameter int unsigned DEF_N_W   = 11;
    parameter int unsigned DEF_SYNC  = 2;

    // Meaning of the control bit (word bit 0).
    typedef enum logic {
        WK_COUNTER   = 1'b0,
        WK_REFERENCE = 1'b1
    } word_kind_e;

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // Word length in bits for each format.
    function automatic int unsigned ref_len(input int unsigned r_w);
        return r_w + 2;
    endfunction

    function automatic int unsigned cnt_len(input int unsigned a_w, input int unsigned n_w);
        return a_w + n_w + 1;
    endfunction

endpackage

// File: rtl/slink_sync.sv
// Multi-stage synchronizer, level output only.
module slink_sync #(
    parameter int unsigned STAGES = slink_pkg::DEF_SYNC
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic lvl
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= din;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= {chain_q[STAGES-2:0], din};
            end
        end
    endgenerate

    assign lvl = chain_q[STAGES-1];
endmodule

// File: rtl/slink_edge.sv
// Synchronizer followed by rising-edge detection on the synchronized level.
module slink_edge #(
    parameter int unsigned STAGES = slink_pkg::DEF_SYNC
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise
);
    logic lvl;
    logic prev_q;

    slink_sync #(.STAGES(STAGES)) sync_i (
        .clk (clk),
        .rst (rst),
        .din (din),
        .lvl (lvl)
    );

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= lvl;
    end

    assign rise = lvl & ~prev_q;
endmodule

// File: rtl/slink_shift.sv
// Shift register plus saturating count of bits since the last strobe.
module slink_shift #(
    parameter int unsigned SHIFT_W = 19,
    localparam int unsigned CW     = $clog2(SHIFT_W + 2)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               shift_stb,
    input  logic               bit_in,
    input  logic               clear_stb,
    output logic [SHIFT_W-1:0] shreg,
    output logic [CW-1:0]      bit_cnt
);
    localparam logic [CW-1:0] CNT_SAT = CW'(SHIFT_W + 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg   <= '0;
            bit_cnt <= '0;
        end else if (clear_stb) begin
            // Strobe wins: a clock edge in the same cycle is dropped.
            bit_cnt <= '0;
        end else if (shift_stb) begin
            shreg <= {shreg[SHIFT_W-2:0], bit_in};
            if (bit_cnt != CNT_SAT) bit_cnt <= bit_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/slink_decode.sv
// Length check and transfer into the selected register bank.
module slink_decode
    import slink_pkg::*;
#(
    parameter int unsigned R_W     = DEF_R_W,
    parameter int unsigned A_W     = DEF_A_W,
    parameter int unsigned N_W     = DEF_N_W,
    parameter int unsigned SHIFT_W = max2(ref_len(R_W), cnt_len(A_W, N_W)),
    localparam int unsigned CW     = $clog2(SHIFT_W + 2)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load_stb,
    input  logic [SHIFT_W-1:0] shreg,
    input  logic [CW-1:0]      bit_cnt,
    output logic [R_W-1:0]     r_val,
    output logic               msel,
    output logic [N_W-1:0]     n_val,
    output logic [A_W-1:0]     a_val,
    output logic               done,
    output logic               err
);
    localparam logic [CW-1:0] REF_LEN_C = CW'(ref_len(R_W));
    localparam logic [CW-1:0] CNT_LEN_C = CW'(cnt_len(A_W, N_W));

    word_kind_e kind;
    logic       ref_ok;
    logic       cnt_ok;

    always_comb begin
        kind   = word_kind_e'(shreg[0]);
        ref_ok = (kind == WK_REFERENCE) && (bit_cnt == REF_LEN_C);
        cnt_ok = (kind == WK_COUNTER)   && (bit_cnt == CNT_LEN_C);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_val <= '0;
            msel  <= 1'b0;
            n_val <= '0;
            a_val <= '0;
            done  <= 1'b0;
            err   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (load_stb) begin
                if (ref_ok) begin
                    r_val <= shreg[R_W:1];
                    msel  <= shreg[R_W+1];
                    done  <= 1'b1;
                    err   <= 1'b0;
                end else if (cnt_ok) begin
                    a_val <= shreg[A_W:1];
                    n_val <= shreg[A_W+N_W:A_W+1];
                    done  <= 1'b1;
                    err   <= 1'b0;
                end else begin
                    err <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/ser_divratio_load.sv
module ser_divratio_load
    import slink_pkg::*;
#(
    parameter int unsigned R_W    = DEF_R_W,
    parameter int unsigned A_W    = DEF_A_W,
    parameter int unsigned N_W    = DEF_N_W,
    parameter int unsigned STAGES = DEF_SYNC
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           ser_clk_i,
    input  logic           ser_dat_i,
    input  logic           ser_ld_i,
    output logic [R_W-1:0] ref_div_o,
    output logic           mod_sel_o,
    output logic [N_W-1:0] main_div_o,
    output logic [A_W-1:0] swal_div_o,
    output logic           load_done_o,
    output logic           len_err_o
);
    localparam int unsigned SHIFT_W = max2(ref_len(R_W), cnt_len(A_W, N_W));
    localparam int unsigned CW      = $clog2(SHIFT_W + 2);

    // Index 0: serial clock, index 1: load strobe.
    logic [1:0]         edge_in;
    logic [1:0]         edge_rise;
    logic               dat_lvl;
    logic [SHIFT_W-1:0] shreg;
    logic [CW-1:0]      bit_cnt;

    assign edge_in = {ser_ld_i, ser_clk_i};

    generate
        for (genvar gi = 0; gi < 2; gi++) begin : g_edge
            slink_edge #(.STAGES(STAGES)) edge_i (
                .clk  (clk),
                .rst  (rst),
                .din  (edge_in[gi]),
                .rise (edge_rise[gi])
            );
        end
    endgenerate

    // Same depth as the clock path, so data stays aligned with its edge.
    slink_sync #(.STAGES(STAGES)) dat_sync_i (
        .clk (clk),
        .rst (rst),
        .din (ser_dat_i),
        .lvl (dat_lvl)
    );

    slink_shift #(.SHIFT_W(SHIFT_W)) shift_i (
        .clk       (clk),
        .rst       (rst),
        .shift_stb (edge_rise[0]),
        .bit_in    (dat_lvl),
        .clear_stb (edge_rise[1]),
        .shreg     (shreg),
        .bit_cnt   (bit_cnt)
    );

    slink_decode #(
        .R_W     (R_W),
        .A_W     (A_W),
        .N_W     (N_W),
        .SHIFT_W (SHIFT_W)
    ) decode_i (
        .clk      (clk),
        .rst      (rst),
        .load_stb (edge_rise[1]),
        .shreg    (shreg),
        .bit_cnt  (bit_cnt),
        .r_val    (ref_div_o),
        .msel     (mod_sel_o),
        .n_val    (main_div_o),
        .a_val    (swal_div_o),
        .done     (load_done_o),
        .err      (len_err_o)
    );
endmodule

// File: rtl/slink_chk.sv
module slink_chk #(
    parameter int unsigned R_W = 14,
    parameter int unsigned A_W = 7,
    parameter int unsigned N_W = 11
) (
    input logic           clk,
    input logic           rst,
    input logic [R_W-1:0] ref_div_o,
    input logic           mod_sel_o,
    input logic [N_W-1:0] main_div_o,
    input logic [A_W-1:0] swal_div_o,
    input logic           load_done_o,
    input logic           len_err_o
);
    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        load_done_o |=> !load_done_o);

    // R2
    ref_bank_done_chk: assert property (@(posedge clk) disable iff (rst)
        (!$stable(ref_div_o) || !$stable(mod_sel_o)) |-> load_done_o);

    // R3
    cnt_bank_done_chk: assert property (@(posedge clk) disable iff (rst)
        (!$stable(main_div_o) || !$stable(swal_div_o)) |-> load_done_o);

    // R2
    one_bank_chk: assert property (@(posedge clk) disable iff (rst)
        (!$stable(ref_div_o) || !$stable(mod_sel_o)) |-> ($stable(main_div_o) && $stable(swal_div_o)));

    // R5
    err_keeps_outputs_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(len_err_o) |-> ($stable(ref_div_o) && $stable(mod_sel_o)
                              && $stable(main_div_o) && $stable(swal_div_o) && !load_done_o));

    // R6
    done_clears_err_chk: assert property (@(posedge clk) disable iff (rst)
        load_done_o |-> !len_err_o);
endmodule

bind ser_divratio_load slink_chk #(.R_W(R_W), .A_W(A_W), .N_W(N_W)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .ref_div_o   (ref_div_o),
    .mod_sel_o   (mod_sel_o),
    .main_div_o  (main_div_o),
    .swal_div_o  (swal_div_o),
    .load_done_o (load_done_o),
    .len_err_o   (len_err_o)
);

// File: tb/ser_divratio_load_tb_top.sv
`timescale 1ns/1ps
module ser_divratio_load_tb_top;
    localparam int R_W    = 14;
    localparam int A_W    = 7;
    localparam int N_W    = 11;
    localparam int STAGES = 3;
    localparam int HOLD   = STAGES + 3;
    localparam int REF_L  = R_W + 2;
    localparam int CNT_L  = A_W + N_W + 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ser_clk = 1'b0, ser_dat = 1'b0, ser_ld = 1'b0;
    logic [R_W-1:0] ref_div;
    logic           mod_sel;
    logic [N_W-1:0] main_div;
    logic [A_W-1:0] swal_div;
    logic           load_done;
    logic           len_err;

    always #10 clk = ~clk;   // 50 MHz

    ser_divratio_load #(.R_W(R_W), .A_W(A_W), .N_W(N_W), .STAGES(STAGES)) dut_i (
        .clk(clk), .rst(rst),
        .ser_clk_i(ser_clk), .ser_dat_i(ser_dat), .ser_ld_i(ser_ld),
        .ref_div_o(ref_div), .mod_sel_o(mod_sel), .main_div_o(main_div),
        .swal_div_o(swal_div), .load_done_o(load_done), .len_err_o(len_err)
    );

    int total = 0;
    int bad = 0;
    bit finished = 0;
    bit settling = 1;
    string cur_req = "R1";

    // Reference model state
    bit   bits_q[$];
    int   exp_r = 0, exp_msel = 0, exp_n = 0, exp_a = 0, exp_err = 0;
    int   exp_done = 0;
    int   seen_done = 0;

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Per-clock comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (!rst) begin
            if (load_done) seen_done++;
            if (!settling) begin
                chk({cur_req, " ref_div"}, int'(ref_div), exp_r);
                chk({cur_req, " mod_sel"}, int'(mod_sel), exp_msel);
                chk({cur_req, " main_div"}, int'(main_div), exp_n);
                chk({cur_req, " swal_div"}, int'(swal_div), exp_a);
                chk({cur_req, " len_err"}, int'(len_err), exp_err);
                chk({cur_req, " R7 done idle"}, int'(load_done), 0);
            end
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input bit b);
        ser_dat = b;       wait_cyc(HOLD);
        ser_clk = 1'b1;    wait_cyc(HOLD);
        ser_clk = 1'b0;    wait_cyc(HOLD);
        bits_q.push_back(b);
    endtask

    task automatic send_word(input longint unsigned w, input int len);
        for (int i = len - 1; i >= 0; i--) send_bit(w[i]);
    endtask

    task automatic pulse_load();
        longint unsigned w = 0;
        int len = bits_q.size();
        foreach (bits_q[i]) w = (w << 1) | longint'(bits_q[i]);
        settling = 1;
        ser_ld = 1'b1;
        wait_cyc(HOLD);
        if (len > 0 && w[0] == 1'b1 && len == REF_L) begin
            exp_r    = int'((w >> 1) & ((64'd1 << R_W) - 1));
            exp_msel = int'((w >> (R_W + 1)) & 1);
            exp_err  = 0;
            exp_done++;
        end else if (len > 0 && w[0] == 1'b0 && len == CNT_L) begin
            exp_a   = int'((w >> 1) & ((64'd1 << A_W) - 1));
            exp_n   = int'((w >> (A_W + 1)) & ((64'd1 << N_W) - 1));
            exp_err = 0;
            exp_done++;
        end else begin
            exp_err = 1;
        end
        bits_q.delete();
        chk({cur_req, " R7 done count"}, seen_done, exp_done);
        settling = 0;
        ser_ld = 1'b0;
        wait_cyc(HOLD);
    endtask

    function automatic longint unsigned ref_word(input int r, input int ms);
        return (longint'(ms & 1) << (R_W + 1)) | (longint'(r) << 1) | 64'd1;
    endfunction

    function automatic longint unsigned cnt_word(input int n, input int a);
        return (longint'(n) << (A_W + 1)) | (longint'(a) << 1);
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        wait_cyc(4);
        rst = 1'b0;
        wait_cyc(1);
        // R1: reset state
        chk("R1 ref_div", int'(ref_div), 0);
        chk("R1 main_div", int'(main_div), 0);
        chk("R1 swal_div", int'(swal_div), 0);
        chk("R1 flags", int'({mod_sel, load_done, len_err}), 0);
        settling = 0;

        cur_req = "R2";
        send_word(ref_word(14'h2A5B, 1), REF_L);
        pulse_load();
        chk("R2 ref_div", int'(ref_div), 14'h2A5B);
        chk("R2 mod_sel", int'(mod_sel), 1);

        cur_req = "R3";
        send_word(cnt_word(11'h5A3, 7'h4C), CNT_L);
        pulse_load();
        chk("R3 main_div", int'(main_div), 11'h5A3);
        chk("R3 swal_div", int'(swal_div), 7'h4C);
        chk("R3 ref kept", int'(ref_div), 14'h2A5B);

        cur_req = "R4";
        send_word(ref_word(1, 0), REF_L);
        pulse_load();
        chk("R4 lowest ref bit", int'(ref_div), 1);
        send_word(cnt_word(11'h400, 7'h01), CNT_L);
        pulse_load();
        chk("R4 top main bit", int'(main_div), 11'h400);
        chk("R4 lowest swal bit", int'(swal_div), 1);

        cur_req = "R5";
        send_word(ref_word(14'h1111, 1) & 64'h7FFF, REF_L - 1);
        pulse_load();
        chk("R5 short word err", int'(len_err), 1);
        chk("R5 ref kept", int'(ref_div), 1);
        send_word(cnt_word(11'h3, 7'h3) & 64'hFFFF, REF_L);
        pulse_load();
        chk("R5 wrong-length counter word", int'(len_err), 1);

        cur_req = "R6";
        send_word(cnt_word(11'h0F0, 7'h55), CNT_L);
        pulse_load();
        chk("R6 err cleared", int'(len_err), 0);

        cur_req = "R8";
        pulse_load();
        chk("R8 empty strobe err", int'(len_err), 1);
        send_word(ref_word(14'h3FFF, 0), REF_L);
        pulse_load();
        pulse_load();
        chk("R8 back-to-back strobe err", int'(len_err), 1);
        chk("R8 ref from first strobe", int'(ref_div), 14'h3FFF);

        cur_req = "R9";
        send_word(cnt_word(11'h7FF, 7'h7F), CNT_L + 1);
        pulse_load();
        chk("R9 one extra bit", int'(len_err), 1);
        send_word(64'hFFFF_FFFF, 30);
        pulse_load();
        chk("R9 far beyond longest", int'(len_err), 1);
        chk("R9 main kept", int'(main_div), 11'h0F0);

        cur_req = "R10";
        for (int k = 0; k < 6; k++) begin
            ser_dat = k[0];
            wait_cyc(HOLD);
        end
        send_word(cnt_word(11'h2C9, 7'h36), CNT_L);
        pulse_load();
        chk("R10 data toggles ignored", int'(len_err), 0);
        chk("R10 main", int'(main_div), 11'h2C9);

        cur_req = "R7";
        chk("R7 total done pulses", seen_done, exp_done);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule